// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (Bus Master)

This block turns parallel stereo PCM samples into a three-wire serial audio stream and is the clock master of that link. It divides the system clock down to a bit clock and derives the word-select clock from it. It then sends each left and right sample word, most significant bit first, in a fixed slot of 32 bit-clock periods. A frame is one left slot followed by one right slot, so word select toggles at the audio sampling rate.

The sample source sees a valid/ready handshake. The block holds one stereo pair. At each frame boundary it raises `smp_ready` for a single system clock and takes the pair offered on that cycle. If no pair is offered, the block repeats the last pair and reports an underrun for that frame. Serial data and word select change only on the falling edge of the bit clock. Word select switches one bit period before the first data bit of each slot, in line with the usual serial audio convention.

The control is a four-state machine. `ST_IDLE` is held during reset. `ST_IDLE -> ST_PRIME` is taken unconditionally on the first clock after reset. `ST_PRIME -> ST_LOW` performs the first frame fetch with the bit clock still low. `ST_LOW -> ST_HIGH` is taken when the low half-period count expires and raises the bit clock. `ST_HIGH -> ST_LOW` is taken when the high half-period count expires; it lowers the bit clock and advances the bit position.

Top module: `audio_i2s_tx`

## Requirements
- R1: While `rst_n` is low, `sck`, `ws`, `sd`, `underrun` and `smp_ready` are all 0.
- R2: In steady operation `sck` is high for N and low for N system clocks, where N = `half_div`, and a value of 0 is treated as 1.
- R3: `ws` and `sd` change only in the system clock cycle in which `sck` falls.
- R4: `ws` = 0 marks the left slot and `ws` = 1 marks the right slot. Each level lasts 32 bit periods, giving a 64-period frame.
- R5: The first data bit of a slot is driven one bit period after `ws` takes that slot's level. It is bit WORD_W-1 of the two's-complement word, and the remaining bits follow MSB first.
- R6: The 32 - WORD_W bit periods after a word's LSB in its slot carry 0.
- R7: `smp_ready` is high for exactly one system clock per frame. That clock ends the last bit period of the right slot, or directly follows reset release for the first frame. A pair is taken when `smp_valid` and `smp_ready` are both 1.
- R8: If `smp_valid` is 0 while `smp_ready` is 1, the next frame repeats the previously taken pair (zeros after reset) and `underrun` is 1 for that frame. `underrun` is 0 for a frame whose pair was taken.
- R9: After reset the first complete slot on the line is a left slot carrying the first pair taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | System clocks per bit-clock half period (0 acts as 1) |
| smp_valid | input | 1 | Stereo pair on `smp_left`/`smp_right` is valid |
| smp_ready | output | 1 | One-cycle frame-boundary fetch strobe |
| smp_left | input | WORD_W | Left sample, two's complement |
| smp_right | input | WORD_W | Right sample, two's complement |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select: 0 left, 1 right |
| sd | output | 1 | Serial data, MSB first |
| underrun | output | 1 | Current frame repeats the previous pair |

## Verification
The frame-boundary fetch falls in the same system clock as the bit-clock fall. On that fall the last bit of the right slot is driven, word select returns low and the new pair is loaded behind it. The bench offers a pair that stays valid only up to the strobe and changes it right after. It also withholds valid at randomly chosen boundaries, so that repeat and fresh frames alternate. A receiver model in the bench rebuilds every slot from the line, sampling at the bit-clock rise. It compares the rebuilt slot with the pair expected at that boundary, so a final right bit corrupted by the reload, or a left word fetched one frame late, shows up as a mismatch.

// File: rtl/atx_pkg.sv
package atx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_LOW   = 2'd2,
        ST_HIGH  = 2'd3
    } atx_state_e;

    localparam int SLOT_BITS  = 32;
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);
endpackage

// File: rtl/atx_halfdiv.sv
module atx_halfdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             half_done
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    // a zero setting behaves as the fastest legal ratio
    assign limit     = (half_div == '0) ? DIV_W'(1) : half_div;
    assign half_done = run && (cnt == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || half_done)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/atx_shifter.sv
module atx_shifter
    import atx_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              take,
    input  logic [WORD_W-1:0] in_left,
    input  logic [WORD_W-1:0] in_right,
    output logic [POS_W-1:0]  pos,
    output logic              boundary,
    output logic              sd_bit
);
    localparam int PAD = SLOT_BITS - WORD_W;

    logic [FRAME_BITS-1:0] shreg;
    logic [WORD_W-1:0]     hold_l;
    logic [WORD_W-1:0]     hold_r;
    logic [WORD_W-1:0]     src_l;
    logic [WORD_W-1:0]     src_r;

    function automatic logic [SLOT_BITS-1:0] to_slot(input logic [WORD_W-1:0] w);
        return SLOT_BITS'(w) << PAD;
    endfunction

    assign boundary = fall && (pos == POS_W'(FRAME_BITS - 1));
    assign src_l    = take ? in_left  : hold_l;
    assign src_r    = take ? in_right : hold_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos    <= POS_W'(FRAME_BITS - 1);
            shreg  <= '0;
            hold_l <= '0;
            hold_r <= '0;
            sd_bit <= 1'b0;
        end else if (fall) begin
            pos    <= pos + 1'b1;
            sd_bit <= shreg[FRAME_BITS-1];
            if (boundary) begin
                hold_l <= src_l;
                hold_r <= src_r;
                shreg  <= {to_slot(src_l), to_slot(src_r)};
            end else begin
                shreg  <= shreg << 1;
            end
        end
    end
endmodule

// File: rtl/audio_i2s_tx.sv
module audio_i2s_tx
    import atx_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              smp_valid,
    output logic              smp_ready,
    input  logic [WORD_W-1:0] smp_left,
    input  logic [WORD_W-1:0] smp_right,
    output logic              sck,
    output logic              ws,
    output logic              sd,
    output logic              underrun
);
    atx_state_e       state;
    atx_state_e       nxt;
    logic             run;
    logic             half_done;
    logic             fall_evt;
    logic             rise_evt;
    logic             boundary;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] pos_next;

    assign run      = (state == ST_LOW) || (state == ST_HIGH);
    assign fall_evt = (state == ST_PRIME) || ((state == ST_HIGH) && half_done);
    assign rise_evt = (state == ST_LOW) && half_done;
    assign pos_next = pos + 1'b1;
    assign smp_ready = boundary;

    atx_halfdiv #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .half_div  (half_div),
        .half_done (half_done)
    );

    atx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall     (fall_evt),
        .take     (smp_valid),
        .in_left  (smp_left),
        .in_right (smp_right),
        .pos      (pos),
        .boundary (boundary),
        .sd_bit   (sd)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = ST_PRIME;
            ST_PRIME: nxt = ST_LOW;
            ST_LOW:   if (half_done) nxt = ST_HIGH;
            ST_HIGH:  if (half_done) nxt = ST_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // line outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck      <= 1'b0;
            ws       <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (rise_evt)
                sck <= 1'b1;
            else if (fall_evt)
                sck <= 1'b0;
            if (fall_evt)
                ws <= pos_next[POS_W-1];
            if (boundary)
                underrun <= !smp_valid;
        end
    end
endmodule

// File: rtl/atx_checker.sv
module atx_checker (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic ws,
    input logic sd,
    input logic smp_valid,
    input logic smp_ready,
    input logic underrun
);
    // R3: serial data moves only with a falling bit clock
    p_sd_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sck) |-> $stable(sd));

    // R3: word select moves only with a falling bit clock
    p_ws_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sck) |-> $stable(ws));

    // R7: fetch strobe lasts a single clock
    p_ready_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> !smp_ready);

    // R7/R4: after the fetch the line is in the left slot with sck low
    p_ready_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> (!sck && !ws));

    // R8: missing pair flags underrun
    p_underrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_ready && !smp_valid) |=> underrun);

    // R8: taken pair clears underrun
    p_underrun_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_ready && smp_valid) |=> !underrun);

    // R8: flag only moves at a frame boundary
    p_underrun_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_ready |=> $stable(underrun));
endmodule

bind audio_i2s_tx atx_checker u_atx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (sck),
    .ws        (ws),
    .sd        (sd),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .underrun  (underrun)
);

// File: tb/audio_i2s_tx_bench.sv
module audio_i2s_tx_bench;
    localparam int BW = 24;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] half_div = 8'd1;
    logic          smp_valid = 1'b0;
    logic          smp_ready;
    logic [BW-1:0] smp_left = '0;
    logic [BW-1:0] smp_right = '0;
    logic          sck, ws, sd, underrun;

    always #10 clk = ~clk;

    audio_i2s_tx #(.WORD_W(BW), .DIV_W(DW)) u_audio_i2s_tx (
        .clk(clk), .rst_n(rst_n), .half_div(half_div),
        .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_left(smp_left), .smp_right(smp_right),
        .sck(sck), .ws(ws), .sd(sd), .underrun(underrun)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // monitor state
    bit          mon_on = 1'b0;
    logic        sck_p, ws_p, sd_p, ws_rise_p;
    logic [31:0] acc;
    int          gap, nrise, rises_since, nchg, nleft, nright;
    logic [63:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] to_slot(input logic [BW-1:0] w);
        return 32'(w) << (32 - BW);
    endfunction

    function automatic int lim_of(input logic [DW-1:0] h);
        return (h == 0) ? 1 : int'(h);
    endfunction

    function automatic logic [2*BW-1:0] corner(input int i);
        case (i % 4)
            0: return {24'h7FFFFF, 24'h800000};
            1: return {24'hFFFFFF, 24'h000001};
            2: return {24'h555555, 24'hAAAAAA};
            default: return {BW'($urandom), BW'($urandom)};
        endcase
    endfunction

    // receiver model, samples between clock edges
    always @(negedge clk) begin
        if (mon_on) begin
            gap++;
            if ((ws !== ws_p || sd !== sd_p) && !(sck_p === 1'b1 && sck === 1'b0))
                chk(1'b0, "R3", "ws/sd moved without sck fall", {ws, sd}, {ws_p, sd_p});
            else if (ws !== ws_p || sd !== sd_p)
                chk(1'b1, "R3", "ws/sd change", 0, 0);
            if (sck === 1'b1 && sck_p === 1'b0) begin
                nrise++;
                rises_since++;
                if (nrise >= 3)
                    chk(gap == 2 * lim_of(half_div), "R2", "sck period", gap, 2 * lim_of(half_div));
                gap = 0;
                if (ws !== ws_rise_p) begin
                    logic [31:0] slot;
                    slot = {acc[30:0], sd};
                    if (nchg > 0)
                        chk(rises_since == 32, "R4", "ws level length", rises_since, 32);
                    nchg++;
                    rises_since = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7", "slot without fetched pair", slot, 0);
                    end else if (ws_rise_p == 1'b0) begin
                        if (nleft == 0 && nright == 0)
                            chk(1'b1, "R9", "first slot is left", 0, 0);
                        chk(slot[31:32-BW] == exp_q[0][63:64-BW], "R5", "left word",
                            slot[31:32-BW], exp_q[0][63:64-BW]);
                        chk(slot[31-BW:0] == '0, "R6", "left padding", slot[31-BW:0], 0);
                        nleft++;
                    end else begin
                        if (nleft == 0)
                            chk(1'b0, "R9", "right slot before left", nright, 0);
                        chk(slot[31:32-BW] == exp_q[0][31:32-BW], "R5", "right word",
                            slot[31:32-BW], exp_q[0][31:32-BW]);
                        chk(slot[31-BW:0] == '0, "R6", "right padding", slot[31-BW:0], 0);
                        void'(exp_q.pop_front());
                        nright++;
                    end
                    acc = '0;
                end else begin
                    acc = {acc[30:0], sd};
                end
                ws_rise_p = ws;
            end
            sck_p = sck;
            ws_p  = ws;
            sd_p  = sd;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 180000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_phase(input logic [DW-1:0] hd, input int nframes,
                             input int pct_valid, input bit directed);
        logic [BW-1:0] last_l, last_r;
        bit pend, exp_u, upd, first_b, ready_p;
        int idx, guard;
        mon_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        half_div = hd;
        smp_valid = 1'b0;
        exp_q.delete();
        repeat (4) @(negedge clk);
        chk({sck, ws, sd, underrun, smp_ready} == 5'b0, "R1", "reset outputs",
            {sck, ws, sd, underrun, smp_ready}, 0);
        sck_p = 0; ws_p = 0; sd_p = 0; ws_rise_p = 0; acc = '0;
        gap = 0; nrise = 0; rises_since = 0; nchg = 0; nleft = 0; nright = 0;
        last_l = '0; last_r = '0;
        idx = 0;
        {smp_left, smp_right} = directed ? corner(idx) : {BW'($urandom), BW'($urandom)};
        smp_valid = (($urandom % 100) < pct_valid);
        idx++;
        pend = 0; upd = 0; first_b = 1; ready_p = 0; guard = 0;
        rst_n = 1'b1;
        mon_on = 1'b1;
        while (nright < nframes && guard < 40000) begin
            @(negedge clk);
            guard++;
            if (pend) begin
                chk(underrun == exp_u, "R8", "underrun flag", underrun, exp_u);
                pend = 0;
            end
            if (upd) begin
                {smp_left, smp_right} = directed ? corner(idx) : {BW'($urandom), BW'($urandom)};
                smp_valid = (($urandom % 100) < pct_valid);
                idx++;
                upd = 0;
            end
            if (smp_ready) begin
                chk(!ready_p, "R7", "ready longer than one clock", ready_p, 0);
                if (!first_b)
                    chk(sck && ws, "R7", "ready outside end of right slot", {sck, ws}, 2'b11);
                first_b = 0;
                if (smp_valid) begin
                    last_l = smp_left;
                    last_r = smp_right;
                end
                exp_q.push_back({to_slot(last_l), to_slot(last_r)});
                exp_u = !smp_valid;
                pend = 1;
                upd = 1;
            end
            ready_p = smp_ready;
        end
        chk(nright >= nframes, "R4", "frames completed", nright, nframes);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        run_phase(8'd1, 12, 100, 1'b1);
        run_phase(8'd2, 15, 70, 1'b0);
        run_phase(8'd0, 6, 0, 1'b0);
        run_phase(8'd3, 10, 50, 1'b0);
        run_phase(8'd1, 8, 60, 1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule